// File: doc/BRIEF.md
# Serial CRC Accumulator with Byte Pattern Matching

This block watches a serial link one bit at a time. On the transmit side it keeps a 16-bit CRC over every outgoing bit. On the receive side it keeps a second 16-bit CRC over every incoming bit. It also compares each complete received byte with four reference bytes.

The first two references each have a don't-care mask. The last two must match exactly. The result of each byte comparison is kept in a per-reference flag vector, and a one-cycle pulse marks a byte that hit any reference.

An optional auto-clear mode restarts the receive CRC whenever a received byte matches a reference. A protocol can use this to begin a new checksum at a sync or header pattern without software help. Framing, bit clocking and the register interface are supplied by neighbouring logic.

Top module: `serial_crc_match`

## Requirements
- R1: Each CRC step uses the polynomial x^16+x^12+x^5+1 (0x1021) and shifts the data bit in MSB-first. While `tx_en` and `tx_crc_en` are both 1, `tx_crc` advances once for each cycle with `tx_bit_vld`=1. The new value is visible after that clock edge. Starting from 0xFFFF, the ASCII bytes "123456789" give 0x29B1.
- R2: While `tx_en`=1 and `tx_crc_en`=0, `tx_crc` holds its value, even when bit strobes arrive.
- R3: While `tx_en`=0, `tx_crc` is loaded with the selected initial value on every clock edge.
- R4: `init_sel`=0 selects the initial value 0x0000, and `init_sel`=1 selects 0xFFFF. The same selection applies to both CRCs. Starting from 0x0000, "123456789" gives 0x31C3.
- R5: While `rx_crc_en`=1, `rx_crc` advances once for each cycle with `rx_bit_vld`=1, using the same step as R1. While `rx_crc_en`=0, `rx_crc` is loaded with the initial value, so reception always starts from it.
- R6: Reference j sits in `cmp_vals[8j+7:8j]`, for j=0..3. References 0 and 1 use the masks `cmp_masks[7:0]` and `cmp_masks[15:8]`. A mask bit of 1 makes that bit position don't-care, and a mask bit of 0 must match. References 2 and 3 are compared on all 8 bits.
- R7: On a cycle with `byte_done`=1, bit j of `match_flags` captures whether `rx_byte` matches reference j. The flags are visible after that edge and are held until the next `byte_done`.
- R8: `match_pulse` is 1 for exactly the one cycle after a `byte_done` whose byte matched at least one reference. Otherwise it is 0.
- R9: When `auto_clr`=1 and `rx_crc_en`=1, a `byte_done` with a matching byte loads `rx_crc` with the initial value. This load wins over a receive bit strobe in the same cycle. A byte that matches nothing, or any byte while `auto_clr`=0, leaves the receive CRC untouched.
- R10: Synchronous reset `rst` clears both CRCs to 0x0000, whatever `init_sel` is. It also clears `match_flags` and `match_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enabled; 0 holds tx CRC at initial value |
| tx_crc_en | input | 1 | Transmit CRC accumulation enable |
| tx_bit_vld | input | 1 | Strobe: one transmit bit this cycle |
| tx_bit | input | 1 | Transmit bit value |
| rx_crc_en | input | 1 | Receive CRC enable; 0 holds rx CRC at initial value |
| rx_bit_vld | input | 1 | Strobe: one received bit this cycle |
| rx_bit | input | 1 | Received bit value |
| byte_done | input | 1 | Strobe: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte |
| init_sel | input | 1 | Initial value select: 0 = 0x0000, 1 = 0xFFFF |
| auto_clr | input | 1 | Re-initialise rx CRC on a byte match |
| cmp_vals | input | 32 | Four reference bytes, reference j at [8j+7:8j] |
| cmp_masks | input | 16 | Don't-care masks for references 0 and 1 |
| tx_crc | output | 16 | Transmit CRC result |
| rx_crc | output | 16 | Receive CRC result |
| match_flags | output | 4 | Per-reference match result of the last byte |
| match_pulse | output | 1 | One-cycle pulse after a matching byte |

## Verification
The bench drives a fixed set of received bytes against chosen references and masks. The set includes bytes that differ from a reference only in masked bits and only in unmasked bits, and bytes that hit a masked and an unmasked reference at once. A design that inverted the mask sense, or applied a mask to references 2 or 3, would report the wrong flag vector. The bench also sends a matching byte in the same cycle as a receive bit strobe with auto-clear on. A design that let the bit update win would leave the receive CRC one step past the initial value. Known check values for the two initial values catch a reflected shift or the wrong polynomial. Reset with `init_sel`=1 catches a design that resets to the selected initial value instead of to zero.

// File: rtl/sercrc_pkg.sv
package sercrc_pkg;

    localparam int          CRC_W      = 16;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam int          SYM_W      = 8;
    localparam int          NUM_CMP    = 4;
    localparam int          NUM_MASKED = 2;

    typedef logic [CRC_W-1:0] crc_t;
    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic {
        SEED_ZERO = 1'b0,
        SEED_ONES = 1'b1
    } seed_e;

    // Per-cycle command to one CRC accumulator
    typedef struct packed {
        logic load_seed;
        logic step;
        logic bit_in;
    } crc_cmd_t;

    // One MSB-first shift of the CRC register
    function automatic crc_t crc_step(input crc_t cur, input logic din);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? crc_t'(CRC_POLY) : crc_t'(0));
    endfunction

    function automatic crc_t seed_value(input seed_e sel);
        return (sel == SEED_ONES) ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
    endfunction

endpackage

// File: rtl/sercrc_accum.sv
module sercrc_accum
    import sercrc_pkg::*;
#(
    parameter crc_t RST_VAL = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  crc_cmd_t cmd,
    input  crc_t     seed,
    output crc_t     crc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= RST_VAL;
        end else if (cmd.load_seed) begin
            crc <= seed;
        end else if (cmd.step) begin
            crc <= crc_step(crc, cmd.bit_in);
        end
    end

endmodule

// File: rtl/sercrc_matcher.sv
module sercrc_matcher
    import sercrc_pkg::*;
#(
    parameter int N_REF    = NUM_CMP,
    parameter int N_MASKED = NUM_MASKED
) (
    input  sym_t                     rx_sym,
    input  logic [N_REF*SYM_W-1:0]   refs,
    input  logic [N_MASKED*SYM_W-1:0] masks,
    output logic [N_REF-1:0]         hit
);

    for (genvar j = 0; j < N_REF; j++) begin : g_ref
        if (j < N_MASKED) begin : g_masked
            // mask bit 1 = don't care
            assign hit[j] = ((rx_sym ^ refs[j*SYM_W +: SYM_W])
                             & ~masks[j*SYM_W +: SYM_W]) == '0;
        end else begin : g_exact
            assign hit[j] = (rx_sym == refs[j*SYM_W +: SYM_W]);
        end
    end

endmodule

// File: rtl/sercrc_match_reg.sv
module sercrc_match_reg
    import sercrc_pkg::*;
#(
    parameter int N_REF = NUM_CMP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [N_REF-1:0] hit_in,
    output logic [N_REF-1:0] flags,
    output logic             pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= capture & (|hit_in);
            if (capture) begin
                flags <= hit_in;
            end
        end
    end

endmodule

// File: rtl/serial_crc_match.sv
module serial_crc_match
    import sercrc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tx_en,
    input  logic                        tx_crc_en,
    input  logic                        tx_bit_vld,
    input  logic                        tx_bit,
    input  logic                        rx_crc_en,
    input  logic                        rx_bit_vld,
    input  logic                        rx_bit,
    input  logic                        byte_done,
    input  logic [SYM_W-1:0]            rx_byte,
    input  logic                        init_sel,
    input  logic                        auto_clr,
    input  logic [NUM_CMP*SYM_W-1:0]    cmp_vals,
    input  logic [NUM_MASKED*SYM_W-1:0] cmp_masks,
    output logic [CRC_W-1:0]            tx_crc,
    output logic [CRC_W-1:0]            rx_crc,
    output logic [NUM_CMP-1:0]          match_flags,
    output logic                        match_pulse
);

    crc_t                seed;
    crc_cmd_t            tx_cmd;
    crc_cmd_t            rx_cmd;
    logic [NUM_CMP-1:0]  hit;
    logic                clr_on_match;

    assign seed = seed_value(seed_e'(init_sel));

    sercrc_matcher #(
        .N_REF    (NUM_CMP),
        .N_MASKED (NUM_MASKED)
    ) u_match (
        .rx_sym (rx_byte),
        .refs   (cmp_vals),
        .masks  (cmp_masks),
        .hit    (hit)
    );

    sercrc_match_reg #(
        .N_REF (NUM_CMP)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .capture (byte_done),
        .hit_in  (hit),
        .flags   (match_flags),
        .pulse   (match_pulse)
    );

    // Match-triggered restart takes priority over a bit step
    assign clr_on_match = auto_clr & byte_done & (|hit);

    always_comb begin
        tx_cmd.load_seed = ~tx_en;
        tx_cmd.step      = tx_crc_en & tx_bit_vld;
        tx_cmd.bit_in    = tx_bit;

        rx_cmd.load_seed = ~rx_crc_en | clr_on_match;
        rx_cmd.step      = rx_bit_vld;
        rx_cmd.bit_in    = rx_bit;
    end

    sercrc_accum #(.RST_VAL('0)) u_tx_crc (
        .clk  (clk),
        .rst  (rst),
        .cmd  (tx_cmd),
        .seed (seed),
        .crc  (tx_crc)
    );

    sercrc_accum #(.RST_VAL('0)) u_rx_crc (
        .clk  (clk),
        .rst  (rst),
        .cmd  (rx_cmd),
        .seed (seed),
        .crc  (rx_crc)
    );

endmodule

// File: rtl/sercrc_chk.sv
module sercrc_chk
    import sercrc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tx_en,
    input logic               tx_crc_en,
    input logic               rx_crc_en,
    input logic               rx_bit_vld,
    input logic               byte_done,
    input logic               init_sel,
    input logic               auto_clr,
    input crc_t               tx_crc,
    input crc_t               rx_crc,
    input logic [NUM_CMP-1:0] match_flags,
    input logic               match_pulse
);

    // R3
    tx_seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> tx_crc == seed_value(seed_e'($past(init_sel))));

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !tx_crc_en) |=> $stable(tx_crc));

    // R5
    rx_seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_crc_en |=> rx_crc == seed_value(seed_e'($past(init_sel))));

    // R5
    rx_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_crc_en && !rx_bit_vld && !byte_done) |=> $stable(rx_crc));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(match_flags));

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (match_flags != '0));

    // R8
    pulse_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> !match_pulse);

    // R9
    auto_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_crc_en && auto_clr && byte_done) |=>
            (match_flags == '0 || rx_crc == seed_value(seed_e'($past(init_sel)))));

endmodule

bind serial_crc_match sercrc_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .tx_crc_en   (tx_crc_en),
    .rx_crc_en   (rx_crc_en),
    .rx_bit_vld  (rx_bit_vld),
    .byte_done   (byte_done),
    .init_sel    (init_sel),
    .auto_clr    (auto_clr),
    .tx_crc      (tx_crc),
    .rx_crc      (rx_crc),
    .match_flags (match_flags),
    .match_pulse (match_pulse)
);

// File: tb/test_serial_crc_match.sv
module test_serial_crc_match;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en, tx_crc_en, tx_bit_vld, tx_bit;
    logic        rx_crc_en, rx_bit_vld, rx_bit;
    logic        byte_done;
    logic [7:0]  rx_byte;
    logic        init_sel, auto_clr;
    logic [31:0] cmp_vals;
    logic [15:0] cmp_masks;
    logic [15:0] tx_crc, rx_crc;
    logic [3:0]  match_flags;
    logic        match_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_crc_match i_serial_crc_match (
        .clk(clk), .rst(rst),
        .tx_en(tx_en), .tx_crc_en(tx_crc_en), .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit),
        .rx_crc_en(rx_crc_en), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .init_sel(init_sel), .auto_clr(auto_clr),
        .cmp_vals(cmp_vals), .cmp_masks(cmp_masks),
        .tx_crc(tx_crc), .rx_crc(rx_crc),
        .match_flags(match_flags), .match_pulse(match_pulse)
    );

    // byte value, expected flags
    localparam logic [11:0] VEC [8] = '{
        {8'hA5, 4'b1001},
        {8'hA0, 4'b0001},
        {8'hAF, 4'b0001},
        {8'hB5, 4'b0000},
        {8'h3C, 4'b0010},
        {8'h3D, 4'b0000},
        {8'h7E, 4'b0100},
        {8'h00, 4'b0000}
    };

    function automatic logic [15:0] model_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_tx(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tx_bit_vld = 1'b1;
            tx_bit     = b[i];
            tick();
        end
        tx_bit_vld = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            rx_bit_vld = 1'b1;
            rx_bit     = b[i];
            tick();
        end
        rx_bit_vld = 1'b0;
    endtask

    task automatic send_check_string_tx();
        for (int k = 0; k < 9; k++) send_tx(8'h31 + 8'(k));
    endtask

    task automatic send_check_string_rx();
        for (int k = 0; k < 9; k++) send_rx(8'h31 + 8'(k));
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp_rx;
        rst = 1'b1;
        tx_en = 1'b0; tx_crc_en = 1'b0; tx_bit_vld = 1'b0; tx_bit = 1'b0;
        rx_crc_en = 1'b0; rx_bit_vld = 1'b0; rx_bit = 1'b0;
        byte_done = 1'b0; rx_byte = 8'h00;
        init_sel = 1'b1; auto_clr = 1'b0;
        cmp_vals  = {8'hA5, 8'h7E, 8'h3C, 8'hA5};
        cmp_masks = {8'h00, 8'h0F};
        @(negedge clk);
        tick(); tick();

        // R10: reset clears to zero even with init_sel=1
        chk("R10 tx_crc reset", tx_crc, 16'h0000);
        chk("R10 rx_crc reset", rx_crc, 16'h0000);
        chk("R10 flags reset", {12'h0, match_flags}, 16'h0000);
        chk("R10 pulse reset", {15'h0, match_pulse}, 16'h0000);

        rst = 1'b0;
        tick();
        // R3 / R4: tx disabled loads 0xFFFF
        chk("R3 tx seed load ones", tx_crc, 16'hFFFF);
        chk("R5 rx seed load ones", rx_crc, 16'hFFFF);

        // R1
        tx_en = 1'b1; tx_crc_en = 1'b1;
        send_check_string_tx();
        chk("R1 tx check value 0xFFFF seed", tx_crc, 16'h29B1);

        // R2
        tx_crc_en = 1'b0;
        send_tx(8'h5A);
        chk("R2 tx hold with crc disabled", tx_crc, 16'h29B1);

        // R3 / R4: zero seed
        tx_en = 1'b0; init_sel = 1'b0;
        tick();
        chk("R3 tx seed load zero", tx_crc, 16'h0000);
        tx_en = 1'b1; tx_crc_en = 1'b1;
        send_check_string_tx();
        chk("R4 tx check value zero seed", tx_crc, 16'h31C3);

        // R5
        init_sel = 1'b1;
        send_rx(8'hC7);
        chk("R5 rx held while disabled", rx_crc, 16'hFFFF);
        rx_crc_en = 1'b1;
        send_check_string_rx();
        chk("R5 rx check value", rx_crc, 16'h29B1);

        // R6 / R7 / R8 table
        rx_crc_en = 1'b0;
        foreach (VEC[v]) begin
            byte_done = 1'b1;
            rx_byte   = VEC[v][11:4];
            tick();
            byte_done = 1'b0;
            chk($sformatf("R6 flags byte %h", VEC[v][11:4]), {12'h0, match_flags}, {12'h0, VEC[v][3:0]});
            chk($sformatf("R8 pulse byte %h", VEC[v][11:4]), {15'h0, match_pulse}, {15'h0, |VEC[v][3:0]});
            rx_byte = 8'hEE;
            tick();
            chk("R7 flags held", {12'h0, match_flags}, {12'h0, VEC[v][3:0]});
            chk("R8 pulse single cycle", {15'h0, match_pulse}, 16'h0000);
        end

        // R9: auto-clear on match
        rx_crc_en = 1'b1;
        tick();
        send_rx(8'h12);
        exp_rx = model_byte(16'hFFFF, 8'h12);
        chk("R5 rx one byte", rx_crc, exp_rx);
        auto_clr = 1'b1; byte_done = 1'b1; rx_byte = 8'h3C;
        tick();
        byte_done = 1'b0;
        chk("R9 auto clear on match", rx_crc, 16'hFFFF);

        // R9: no effect when auto_clr=0
        auto_clr = 1'b0;
        send_rx(8'h12);
        byte_done = 1'b1; rx_byte = 8'h3C;
        tick();
        byte_done = 1'b0;
        chk("R9 no clear when auto_clr=0", rx_crc, exp_rx);

        // R9: no effect on non-matching byte
        auto_clr = 1'b1; byte_done = 1'b1; rx_byte = 8'h00;
        tick();
        byte_done = 1'b0;
        chk("R9 no clear on miss", rx_crc, exp_rx);

        // R9: clear wins over same-cycle bit
        byte_done = 1'b1; rx_byte = 8'h7E; rx_bit_vld = 1'b1; rx_bit = 1'b1;
        tick();
        byte_done = 1'b0; rx_bit_vld = 1'b0;
        chk("R9 clear beats bit step", rx_crc, 16'hFFFF);
        chk("R6 exact reference 2", {12'h0, match_flags}, 16'h0004);

        // R6: full mask on reference 1 matches anything
        auto_clr = 1'b0;
        cmp_masks = {8'hFF, 8'h0F};
        byte_done = 1'b1; rx_byte = 8'h00;
        tick();
        byte_done = 1'b0;
        chk("R6 full mask reference 1", {12'h0, match_flags}, 16'h0002);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule